// File: doc/BRIEF.md
# Shadow RAM Transfer Controller

This block fronts a 512-byte volatile array that has a full-size nonvolatile twin behind it. A host reaches it through four active-low strobes: chip select, write strobe, nonvolatile strobe and output strobe. The block decodes them into one of a small set of operating modes. It serves byte reads and byte writes to the volatile array. It drives an enable for the data bus only while a read is legal. It also sequences whole-array copies in either direction. A copy from the nonvolatile side into RAM is a recall. A copy from RAM into the nonvolatile side is a store.

A recall is started in two ways. It runs by itself once, right after reset, which models power-up. The host can also request one with a dedicated strobe pattern. A store is never started by the strobes alone. It comes from a separate request input, which a protection or command unit would drive, and it is refused while the output strobe is low.

After reset, two start-up windows apply. RAM accesses are accepted only after the first window. Host-requested transfers are accepted only after the second, longer window. While a copy is in progress the busy output stays high, and every host access or request is dropped.

Top module: `shadow_xfer_ctrl`

## Requirements
- R1: The `mode` output decodes the strobes as follows. 0 is idle, which covers chip select high (any other strobes), the output-disabled pattern and the no-op pattern (nonvolatile strobe low, write and output strobes high). 1 is read: select and output strobe low, write and nonvolatile strobes high. 2 is write: select and write strobe low, nonvolatile strobe high. 3 is recall: select, nonvolatile and output strobes low, write strobe high. 4 is command: select, write and nonvolatile strobes low, output strobe high. 5 is illegal: all four low.
- R2: `rdata_en` is 1 only in mode 1 while not busy and after the RAM start-up window. In that case `rdata` combinationally shows the byte at `addr`. In every other case `rdata_en` is 0 and `rdata` is 0, including during reset.
- R3: A byte is written into RAM at a rising clock edge only in mode 2, with the output strobe either level. The command and illegal modes never alter RAM.
- R4: After reset is released, `busy` is high for exactly RECALL_CYC rising edges. By the end, every RAM byte equals its nonvolatile twin.
- R5: For the first PU_RAM_CYC rising edges after reset, RAM reads give `rdata_en` = 0 and RAM writes are ignored.
- R6: Entering mode 3 starts one recall. `busy` rises at the next edge and stays high for RECALL_CYC edges, and the whole RAM is then reloaded from the nonvolatile array. Holding the pattern does not start a second recall, and the bus stays disabled throughout.
- R7: A `store_req` sampled high with the output strobe high starts a store. `busy` stays high for STORE_CYC edges, and the nonvolatile array then holds the RAM contents.
- R8: A `store_req` sampled while the output strobe is low is ignored.
- R9: During the first PU_NV_CYC edges after reset, recall patterns and `store_req` are ignored.
- R10: While `busy` is high, reads give no bus drive, writes are ignored, and recall or store requests are dropped rather than queued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, models power-up |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| nv_n | input | 1 | Nonvolatile strobe, active low |
| oe_n | input | 1 | Output strobe, active low |
| addr | input | 9 | Byte address |
| wdata | input | 8 | Write data |
| store_req | input | 1 | Store request from the protection/command unit |
| rdata | output | 8 | Read data, zero when not driving |
| rdata_en | output | 1 | Data bus drive enable |
| busy | output | 1 | High while a recall or store runs |
| mode | output | 3 | Decoded strobe mode |

## Verification
The bench sweeps all sixteen strobe patterns. A decoder that treated the all-low or no-op pattern as a write or a recall would either corrupt RAM or show a wrong mode code. It probes the gap between the end of the power-up recall and the end of the RAM start-up window: a controller that opened RAM when the copy finished would accept a write there, and that write would show on a later read. It holds the recall pattern for the whole copy, where a level-triggered start would restart and keep `busy` high. It also issues stores with the output strobe low and issues requests during a copy, where a design that queued or accepted them would show a late second busy period or a changed array.

// File: rtl/shadow_pkg.sv
package shadow_pkg;

    // Decoded strobe modes, the code appears on the mode output
    typedef enum logic [2:0] {
        MODE_IDLE    = 3'd0,
        MODE_READ    = 3'd1,
        MODE_WRITE   = 3'd2,
        MODE_RECALL  = 3'd3,
        MODE_CMD     = 3'd4,
        MODE_ILLEGAL = 3'd5
    } strobe_mode_e;

    // Whole-array transfer engine states
    typedef enum logic [1:0] {
        XF_IDLE   = 2'd0,
        XF_RECALL = 2'd1,
        XF_STORE  = 2'd2
    } xfer_state_e;

    // Active-low host strobes bundled together
    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic nv_n;
        logic oe_n;
    } strobe_t;

    function automatic strobe_mode_e decode_strobes(input strobe_t s);
        strobe_mode_e m;
        if (s.ce_n) begin
            m = MODE_IDLE;
        end else if (s.nv_n) begin
            if (!s.we_n)      m = MODE_WRITE;
            else if (!s.oe_n) m = MODE_READ;
            else              m = MODE_IDLE;
        end else begin
            if (!s.we_n) m = s.oe_n ? MODE_CMD : MODE_ILLEGAL;
            else         m = s.oe_n ? MODE_IDLE : MODE_RECALL;
        end
        return m;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/shadow_strobe_decode.sv
module shadow_strobe_decode
    import shadow_pkg::*;
(
    input  strobe_t      strobes,
    output strobe_mode_e mode
);

    always_comb begin
        mode = decode_strobes(strobes);
    end

endmodule

// File: rtl/shadow_powerup.sv
module shadow_powerup #(
    parameter int unsigned PU_RAM_CYC = 700,
    parameter int unsigned PU_NV_CYC  = 1500
) (
    input  logic clk,
    input  logic rst,
    output logic ram_ok,
    output logic nv_ok
);

    localparam int unsigned PU_W = $clog2(PU_NV_CYC + 1);

    logic [PU_W-1:0] pu_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            pu_cnt <= '0;
        end else if (pu_cnt != PU_W'(PU_NV_CYC)) begin
            pu_cnt <= pu_cnt + 1'b1;
        end
    end

    assign ram_ok = (pu_cnt >= PU_W'(PU_RAM_CYC));
    assign nv_ok  = (pu_cnt == PU_W'(PU_NV_CYC));

    AST_NV_AFTER_RAM: assert property (@(posedge clk) disable iff (rst)
        nv_ok |-> ram_ok) else $error("nv ready before ram ready"); // R9
    AST_RAM_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
        ram_ok |=> ram_ok) else $error("ram ready dropped"); // R5

endmodule

// File: rtl/shadow_xfer_seq.sv
module shadow_xfer_seq
    import shadow_pkg::*;
#(
    parameter int unsigned DEPTH      = 512,
    parameter int unsigned ADDR_W     = 9,
    parameter int unsigned RECALL_CYC = 600,
    parameter int unsigned STORE_CYC  = 1200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_recall,
    input  logic              start_store,
    output xfer_state_e       state,
    output logic              busy,
    output logic              copy_en,
    output logic [ADDR_W-1:0] copy_idx
);

    // Both durations must be at least DEPTH so that every byte is copied
    localparam int unsigned LONGEST = max_u(RECALL_CYC, STORE_CYC);
    localparam int unsigned CNT_W   = $clog2(LONGEST + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            // power-up recall begins straight out of reset
            state <= XF_RECALL;
            cnt   <= '0;
        end else begin
            unique case (state)
                XF_IDLE: begin
                    cnt <= '0;
                    if (start_recall)     state <= XF_RECALL;
                    else if (start_store) state <= XF_STORE;
                end
                XF_RECALL: begin
                    if (cnt == CNT_W'(RECALL_CYC - 1)) begin
                        state <= XF_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                XF_STORE: begin
                    if (cnt == CNT_W'(STORE_CYC - 1)) begin
                        state <= XF_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    state <= XF_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    assign busy     = (state != XF_IDLE);
    assign copy_en  = busy && (32'(cnt) < 32'(DEPTH));
    assign copy_idx = ADDR_W'(cnt);

    AST_RECALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state == XF_RECALL && cnt != CNT_W'(RECALL_CYC - 1)) |=> (state == XF_RECALL))
        else $error("recall ended early"); // R4
    AST_STORE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state == XF_STORE && cnt != CNT_W'(STORE_CYC - 1)) |=> (state == XF_STORE))
        else $error("store ended early"); // R7
    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != '0) |=> ($past(state) == state) || (state == XF_IDLE))
        else $error("transfer switched kind mid-copy"); // R10

endmodule

// File: rtl/shadow_arrays.sv
module shadow_arrays #(
    parameter int unsigned DEPTH  = 512,
    parameter int unsigned ADDR_W = 9,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              copy_en,
    input  logic              copy_to_nv,
    input  logic [ADDR_W-1:0] copy_idx
);

    logic [DATA_W-1:0] ram_q [DEPTH];
    logic [DATA_W-1:0] nvm_q [DEPTH];

    // volatile array: host writes or recall copies
    always_ff @(posedge clk) begin
        if (host_we) begin
            ram_q[host_addr] <= host_wdata;
        end else if (copy_en && !copy_to_nv) begin
            ram_q[copy_idx] <= nvm_q[copy_idx];
        end
    end

    // nonvolatile array: only store copies touch it
    always_ff @(posedge clk) begin
        if (copy_en && copy_to_nv) begin
            nvm_q[copy_idx] <= ram_q[copy_idx];
        end
    end

    assign host_rdata = ram_q[host_addr];

    AST_NO_HOST_DURING_COPY: assert property (@(posedge clk) disable iff (rst)
        host_we |-> !copy_en) else $error("host write overlaps copy"); // R10

endmodule

// File: rtl/shadow_xfer_ctrl.sv
module shadow_xfer_ctrl
    import shadow_pkg::*;
#(
    parameter int unsigned ADDR_W     = 9,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned RECALL_CYC = 600,
    parameter int unsigned STORE_CYC  = 1200,
    parameter int unsigned PU_RAM_CYC = 700,
    parameter int unsigned PU_NV_CYC  = 1500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              nv_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              store_req,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_en,
    output logic              busy,
    output logic [2:0]        mode
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    strobe_t           strb;
    strobe_mode_e      cur_mode;
    xfer_state_e       xf_state;
    logic              ram_ok;
    logic              nv_ok;
    logic              access_ok;
    logic              host_we;
    logic              recall_seen;
    logic              start_recall;
    logic              start_store;
    logic              copy_en;
    logic [ADDR_W-1:0] copy_idx;
    logic [DATA_W-1:0] arr_rdata;

    assign strb = '{ce_n: ce_n, we_n: we_n, nv_n: nv_n, oe_n: oe_n};

    shadow_strobe_decode u_decode (
        .strobes (strb),
        .mode    (cur_mode)
    );

    shadow_powerup #(
        .PU_RAM_CYC (PU_RAM_CYC),
        .PU_NV_CYC  (PU_NV_CYC)
    ) u_powerup (
        .clk    (clk),
        .rst    (rst),
        .ram_ok (ram_ok),
        .nv_ok  (nv_ok)
    );

    // a recall request is the entry into the recall pattern
    always_ff @(posedge clk) begin
        if (rst) recall_seen <= 1'b0;
        else     recall_seen <= (cur_mode == MODE_RECALL);
    end

    assign start_recall = (cur_mode == MODE_RECALL) && !recall_seen && nv_ok && !busy;
    assign start_store  = store_req && oe_n && nv_ok && !busy;

    shadow_xfer_seq #(
        .DEPTH      (DEPTH),
        .ADDR_W     (ADDR_W),
        .RECALL_CYC (RECALL_CYC),
        .STORE_CYC  (STORE_CYC)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start_recall (start_recall),
        .start_store  (start_store),
        .state        (xf_state),
        .busy         (busy),
        .copy_en      (copy_en),
        .copy_idx     (copy_idx)
    );

    assign access_ok = ram_ok && !busy;
    assign host_we   = (cur_mode == MODE_WRITE) && access_ok;

    shadow_arrays #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_arrays (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_addr  (addr),
        .host_wdata (wdata),
        .host_rdata (arr_rdata),
        .copy_en    (copy_en),
        .copy_to_nv (xf_state == XF_STORE),
        .copy_idx   (copy_idx)
    );

    assign rdata_en = (cur_mode == MODE_READ) && access_ok;
    assign rdata    = rdata_en ? arr_rdata : '0;
    assign mode     = cur_mode;

    AST_BUS_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
        rdata_en |-> (!ce_n && !oe_n && we_n && nv_n)) else $error("bus driven outside read"); // R2
    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (rst)
        ce_n |-> (!rdata_en && !host_we)) else $error("deselected but active"); // R1
    AST_RECALL_FLOAT: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == MODE_RECALL) |-> !rdata_en) else $error("bus driven in recall"); // R6
    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!rdata_en && !host_we)) else $error("host access while busy"); // R10
    AST_STORE_NEEDS_OE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (xf_state == XF_STORE && $past(xf_state) == XF_IDLE) |-> $past(oe_n))
        else $error("store started with output strobe low"); // R8
    AST_NV_GATED: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(nv_ok)) else $error("transfer before nv window"); // R9

endmodule

// File: tb/test_shadow_xfer_ctrl.sv
module test_shadow_xfer_ctrl;

    localparam int RECALL_CYC = 600;
    localparam int STORE_CYC  = 1200;
    localparam int PU_RAM_CYC = 700;
    localparam int PU_NV_CYC  = 1500;
    localparam int DEPTH      = 512;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ce_n = 1'b1, we_n = 1'b1, nv_n = 1'b1, oe_n = 1'b1;
    logic [8:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       store_req = 1'b0;
    logic [7:0] rdata;
    logic       rdata_en;
    logic       busy;
    logic [2:0] mode;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int seed_dummy;

    logic [7:0] ram_m [DEPTH];
    logic [7:0] nvm_m [DEPTH];

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    shadow_xfer_ctrl i_shadow_xfer_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ce_n      (ce_n),
        .we_n      (we_n),
        .nv_n      (nv_n),
        .oe_n      (oe_n),
        .addr      (addr),
        .wdata     (wdata),
        .store_req (store_req),
        .rdata     (rdata),
        .rdata_en  (rdata_en),
        .busy      (busy),
        .mode      (mode)
    );

    function automatic int exp_mode(input logic c, input logic w, input logic n, input logic o);
        if (c) return 0;
        case ({w, n, o})
            3'b110:         return 1;
            3'b010, 3'b011: return 2;
            3'b100:         return 3;
            3'b001:         return 4;
            3'b000:         return 5;
            default:        return 0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_strobes(input logic c, input logic w, input logic n, input logic o);
        ce_n = c; we_n = w; nv_n = n; oe_n = o;
    endtask

    task automatic go_idle();
        @(negedge clk);
        set_strobes(1, 1, 1, 1);
    endtask

    task automatic do_write(input int a, input logic [7:0] d, input bit takes);
        @(negedge clk);
        addr = 9'(a); wdata = d;
        set_strobes(0, 0, 1, 1);
        go_idle();
        if (takes) ram_m[a] = d;
    endtask

    task automatic do_read(input int a, input string req);
        @(negedge clk);
        addr = 9'(a);
        set_strobes(0, 1, 1, 0);
        #2;
        chk(rdata_en == 1'b1, req, int'(rdata_en), 1);
        chk(rdata == ram_m[a], req, int'(rdata), int'(ram_m[a]));
    endtask

    task automatic do_read_blocked(input int a, input string req);
        @(negedge clk);
        addr = 9'(a);
        set_strobes(0, 1, 1, 0);
        #2;
        chk(rdata_en == 1'b0, req, int'(rdata_en), 0);
        chk(rdata == 8'h00, req, int'(rdata), 0);
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic wait_idle();
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (busy && guard < 5000);
    endtask

    task automatic power_cycle();
        @(negedge clk);
        rst = 1'b1;
        set_strobes(1, 1, 1, 1);
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(10 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int t0;
        seed_dummy = $urandom(32'h5EED_0C05);

        // reset state
        repeat (3) @(negedge clk);
        chk(rdata_en == 1'b0, "R2 reset", int'(rdata_en), 0);
        chk(rdata == 8'h00, "R2 reset data", int'(rdata), 0);
        rst = 1'b0;

        // power-up recall length, R4
        wait_idle();
        chk(cyc == RECALL_CYC, "R4 power-up recall length", cyc, RECALL_CYC);

        // RAM window still closed, R5
        wait_cyc(605);
        do_read_blocked(0, "R5 read before ram window");
        go_idle();

        // mode sweep of all sixteen patterns, R1/R2
        wait_cyc(PU_RAM_CYC + 5);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            addr = 9'd0; wdata = 8'h00;
            set_strobes(i[3], i[2], i[1], i[0]);
            #2;
            chk(int'(mode) == exp_mode(i[3], i[2], i[1], i[0]), "R1 mode decode",
                int'(mode), exp_mode(i[3], i[2], i[1], i[0]));
            chk(rdata_en == (exp_mode(i[3], i[2], i[1], i[0]) == 1), "R2 drive only in read",
                int'(rdata_en), int'(exp_mode(i[3], i[2], i[1], i[0]) == 1));
        end
        go_idle();

        // nonvolatile window still closed, R9
        @(negedge clk);
        set_strobes(0, 1, 0, 0);
        @(negedge clk);
        chk(busy == 1'b0, "R9 early recall ignored", int'(busy), 0);
        set_strobes(1, 1, 1, 1);
        store_req = 1'b1;
        @(negedge clk);
        store_req = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R9 early store ignored", int'(busy), 0);

        // fill the RAM, R3
        for (int a = 0; a < DEPTH; a++) do_write(a, 8'($urandom), 1);
        do_read(0, "R3 low boundary");
        do_read(DEPTH - 1, "R3 high boundary");
        for (int k = 0; k < 32; k++) do_read(int'($urandom % DEPTH), "R3 fill readback");

        // command and illegal patterns leave RAM alone, R3
        @(negedge clk);
        addr = 9'd3; wdata = ~ram_m[3];
        set_strobes(0, 0, 0, 1);
        @(negedge clk);
        set_strobes(0, 0, 0, 0);
        go_idle();
        do_read(3, "R3 command/illegal no write");
        // write with output strobe low still writes
        @(negedge clk);
        addr = 9'd4; wdata = 8'h3C;
        set_strobes(0, 0, 1, 0);
        go_idle();
        ram_m[4] = 8'h3C;
        do_read(4, "R3 write with output strobe low");
        go_idle();

        // store refused with output strobe low, R8
        wait_cyc(PU_NV_CYC + 2);
        @(negedge clk);
        set_strobes(1, 1, 1, 0);
        store_req = 1'b1;
        @(negedge clk);
        store_req = 1'b0;
        oe_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R8 store blocked", int'(busy), 0);
        @(negedge clk);
        chk(busy == 1'b0, "R8 store still blocked", int'(busy), 0);

        // store, with traffic during the copy, R7/R10
        @(negedge clk);
        t0 = cyc;
        set_strobes(1, 1, 1, 1);
        store_req = 1'b1;
        @(negedge clk);
        store_req = 1'b0;
        chk(busy == 1'b1, "R7 store started", int'(busy), 1);
        for (int a = 0; a < DEPTH; a++) nvm_m[a] = ram_m[a];
        addr = 9'd7; wdata = ~ram_m[7];
        set_strobes(0, 0, 1, 1);
        do_read_blocked(7, "R10 read while busy");
        @(negedge clk);
        set_strobes(1, 1, 1, 1);
        store_req = 1'b1;
        @(negedge clk);
        store_req = 1'b0;
        wait_idle();
        chk(cyc == t0 + 1 + STORE_CYC, "R7 store length", cyc, t0 + 1 + STORE_CYC);
        @(negedge clk);
        chk(busy == 1'b0, "R10 dropped request not queued", int'(busy), 0);
        do_read(7, "R10 write during store ignored");
        go_idle();

        // dirty some RAM, then recall with the pattern held, R6
        for (int a = 0; a < 8; a++) do_write(a, ~nvm_m[a], 1);
        @(negedge clk);
        t0 = cyc;
        addr = 9'd1;
        set_strobes(0, 1, 0, 0);
        #2;
        chk(rdata_en == 1'b0, "R6 bus floats in recall", int'(rdata_en), 0);
        wait_idle();
        chk(cyc == t0 + 1 + RECALL_CYC, "R6 recall length", cyc, t0 + 1 + RECALL_CYC);
        repeat (3) begin
            @(negedge clk);
            chk(busy == 1'b0, "R6 held pattern no restart", int'(busy), 0);
        end
        go_idle();
        for (int a = 0; a < DEPTH; a++) ram_m[a] = nvm_m[a];
        for (int a = 0; a < 8; a++) do_read(a, "R6 recalled data");
        go_idle();

        // power cycle: automatic recall, RAM window, R4/R5
        do_write(10, ~nvm_m[10], 1);
        power_cycle();
        wait_idle();
        chk(cyc == RECALL_CYC, "R4 second power-up length", cyc, RECALL_CYC);
        for (int a = 0; a < DEPTH; a++) ram_m[a] = nvm_m[a];
        wait_cyc(620);
        do_write(9, ~nvm_m[9], 0);
        wait_cyc(630);
        do_read_blocked(9, "R5 read in closed window");
        go_idle();
        wait_cyc(PU_RAM_CYC + 5);
        do_read(9, "R5 early write ignored");
        do_read(10, "R4 restored after power cycle");
        for (int k = 0; k < 24; k++) do_read(int'($urandom % DEPTH), "R4 restored random");
        go_idle();

        // random mix of reads, writes and strobe patterns
        for (int it = 0; it < 300; it++) begin
            int op = int'($urandom % 3);
            int a  = int'($urandom % DEPTH);
            if (op == 0) begin
                do_read(a, "R2 random read");
            end else if (op == 1) begin
                do_write(a, 8'($urandom), 1);
            end else begin
                logic [3:0] s = 4'($urandom);
                logic [7:0] d = 8'($urandom);
                int em;
                if (s == 4'b0100) s = 4'b0101; // avoid recall pattern
                em = exp_mode(s[3], s[2], s[1], s[0]);
                @(negedge clk);
                addr = 9'(a); wdata = d;
                set_strobes(s[3], s[2], s[1], s[0]);
                #2;
                chk(int'(mode) == em, "R1 random pattern", int'(mode), em);
                if (em == 1) chk(rdata == ram_m[a], "R2 random pattern read", int'(rdata), int'(ram_m[a]));
                else chk(rdata_en == 1'b0, "R2 random pattern no drive", int'(rdata_en), 0);
                go_idle();
                if (em == 2) ram_m[a] = d;
            end
        end
        go_idle();
        for (int k = 0; k < 16; k++) do_read(int'($urandom % DEPTH), "R3 final readback");
        go_idle();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule